// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects up to 64 level-sensitive interrupt requests, arranged in groups of eight, and drives two interrupt lines toward a processor: a low line and a high line. Software programs it through a small word-addressed register file. Each source has an enable bit. Each group has a priority word whose ranked slots name, in order, which group members matter most. A routing word lets the two best slots of each group signal on the high line. A control word names one source that beats every other source and picks the line it drives.

For each line the block reports the number of the winning source in a read-only vector word. It recomputes both vectors and both lines every cycle from the live request levels and the programmed state. A handler reads the vector of the line that fired, services that source, and reads again until the vector shows zero.

Sources are numbered `8*g + p`, where `g` is the group (0..NUM_GROUPS-1, in tie-break order) and `p` is the member position (0..7). Source 0 does not exist, so a vector value of 0 means that nothing is pending.

Top module: `gpic`

## Requirements
- R1: After reset the control, routing, enable and priority state is all zero, both vector words read 0 and both lines stay low whatever the request levels are.
- R2: Enable bit `b` of enable word `w` (address 4+w) gates source `32*w+b`, and 1 enables it. A disabled source, and source 0, never drives a line or appears in a vector.
- R3: Both lines are level outputs with no register on the way. In the same cycle, a line is high exactly when its vector is non-zero.
- R4: The low vector (address 2) and the high vector (address 3) carry the winning source number in bits 31:26, with bits 25:0 zero and 0 meaning none. Writes to these two addresses change no state.
- R5: Priority word of group g (address 8+g) holds slot 1 in bits 31:29, slot 2 in 28:26, slot 3 in 25:23 and slots 4..8 in 14:12, 11:9, 8:6, 5:3 and 2:0. Each slot holds a member position. Bits 22:15 read as zero.
- R6: A member's rank is the lowest-numbered slot that holds its position. On each line, a lower rank wins.
- R7: A member named in no slot ranks below slot 8. Equal ranks inside one group go to the lower position.
- R8: Equal ranks in different groups go to the lower group index.
- R9: The routing word (address 1) has a 2-bit field per group. Slot 1 of group g sits at bits 4g+3:4g+2 and slot 2 at bits 4g+1:4g. A field value of 01 sends the member ranked in that slot to the high line, and any other value keeps it on the low line. Ranks 3..8 and unlisted members always use the low line.
- R10: The control word (address 0) holds a designated source number in bits 5:0 and its line select in bits 9:8, where 01 selects high and anything else selects low. When that source is pending and enabled, it wins its line over all others. It never takes part in slot arbitration, so it never appears on the other line. A value of 0, or a number at or above the source count, designates nothing.
- R11: A write takes effect at the next clock edge. The control, routing, enable and priority words read back with unused bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_GROUPS*8 | Request levels, bit n is source n |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| irq_lo | output | 1 | Low interrupt line |
| irq_hi | output | 1 | High interrupt line |

## Verification
A fixed configuration is loaded first. It puts one member of one group on the high line through a slot-1 route and one member of another group through a slot-2 route. It gives one group a route field of 10, which must not count as high. It leaves one source disabled. A table of request patterns is then applied. Single sources tell routing apart from ranking. Pairs at equal slots in different groups show the group tie order. Pairs inside one group at different slots show slot ranking, and unlisted members show the lowest-rank and position tie rules. The all-ones pattern checks both lines at once. Directed steps then cover the reset image, write-ignore on the vector addresses, slot-bit placement on readback, the designated source on each line (including a disabled one), and a reset in the middle of operation.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
    localparam int GRP_SIZE  = 8;
    localparam int SLOTS     = 8;
    localparam int CODE_W    = 3;
    localparam int RANK_W    = 4;
    localparam int SRC_W     = 6;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int VEC_LSB   = 26;

    localparam int A_CTRL    = 0;
    localparam int A_ROUTE   = 1;
    localparam int A_VEC_LO  = 2;
    localparam int A_VEC_HI  = 3;
    localparam int A_MASK    = 4;
    localparam int A_PRIO    = 8;

    localparam logic [1:0] LINE_HIGH = 2'b01;

    // lowest bit of ranked slot k (k = 0 is slot 1)
    function automatic int slot_lsb(input int k);
        return (k < 3) ? (29 - 3 * k) : (12 - 3 * (k - 3));
    endfunction
endpackage

// File: rtl/gpic_regs.sv
module gpic_regs
    import gpic_pkg::*;
#(
    parameter int NUM_GROUPS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic [DATA_W-1:0]                  vec_lo,
    input  logic [DATA_W-1:0]                  vec_hi,
    output logic [DATA_W-1:0]                  rdata,
    output logic [SRC_W-1:0]                   desig_src,
    output logic [1:0]                         desig_line,
    output logic [NUM_GROUPS*4-1:0]            route,
    output logic [NUM_GROUPS*GRP_SIZE-1:0]     mask,
    output logic [NUM_GROUPS*SLOTS*CODE_W-1:0] slots
);
    localparam int N_SRC = NUM_GROUPS * GRP_SIZE;
    localparam int MW    = (N_SRC + 31) / 32;
    localparam int RW    = NUM_GROUPS * 4;

    typedef struct packed {
        logic [SRC_W-1:0]                                dsrc;
        logic [1:0]                                      dline;
        logic [RW-1:0]                                   route;
        logic [N_SRC-1:0]                                mask;
        logic [NUM_GROUPS-1:0][SLOTS-1:0][CODE_W-1:0]    code;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (addr == ADDR_W'(A_CTRL)) begin
                st_d.dsrc  = wdata[SRC_W-1:0];
                st_d.dline = wdata[9:8];
            end
            if (addr == ADDR_W'(A_ROUTE))
                st_d.route = wdata[RW-1:0];
            for (int w = 0; w < MW; w++)
                if (addr == ADDR_W'(A_MASK + w))
                    for (int b = 0; b < N_SRC; b++)
                        if (b / 32 == w) st_d.mask[b] = wdata[b % 32];
            for (int g = 0; g < NUM_GROUPS; g++)
                if (addr == ADDR_W'(A_PRIO + g))
                    for (int k = 0; k < SLOTS; k++)
                        st_d.code[g][k] = wdata[slot_lsb(k) +: CODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL)) begin
            rdata[SRC_W-1:0] = st_q.dsrc;
            rdata[9:8]       = st_q.dline;
        end
        if (addr == ADDR_W'(A_ROUTE))  rdata[RW-1:0] = st_q.route;
        if (addr == ADDR_W'(A_VEC_LO)) rdata = vec_lo;
        if (addr == ADDR_W'(A_VEC_HI)) rdata = vec_hi;
        for (int w = 0; w < MW; w++)
            if (addr == ADDR_W'(A_MASK + w))
                for (int b = 0; b < N_SRC; b++)
                    if (b / 32 == w) rdata[b % 32] = st_q.mask[b];
        for (int g = 0; g < NUM_GROUPS; g++)
            if (addr == ADDR_W'(A_PRIO + g))
                for (int k = 0; k < SLOTS; k++)
                    rdata[slot_lsb(k) +: CODE_W] = st_q.code[g][k];
    end

    assign desig_src  = st_q.dsrc;
    assign desig_line = st_q.dline;
    assign route      = st_q.route;
    assign mask       = st_q.mask;
    assign slots      = st_q.code;

    // R4: the vector addresses are read-only
    p_vec_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == ADDR_W'(A_VEC_LO) || addr == ADDR_W'(A_VEC_HI)))
        |=> $stable(st_q));
endmodule

// File: rtl/gpic_rank.sv
module gpic_rank
    import gpic_pkg::*;
(
    input  logic [SLOTS*CODE_W-1:0]    codes,
    input  logic [3:0]                 route4,
    output logic [GRP_SIZE*RANK_W-1:0] rank,
    output logic [GRP_SIZE-1:0]        to_hi
);
    always_comb begin
        rank  = '0;
        to_hi = '0;
        for (int p = 0; p < GRP_SIZE; p++) begin
            logic [RANK_W-1:0] r;
            r = RANK_W'(SLOTS);
            for (int k = SLOTS - 1; k >= 0; k--)
                if (codes[k*CODE_W +: CODE_W] == CODE_W'(p)) r = RANK_W'(k);
            rank[p*RANK_W +: RANK_W] = r;
            to_hi[p] = (r == RANK_W'(0) && route4[3:2] == LINE_HIGH) ||
                       (r == RANK_W'(1) && route4[1:0] == LINE_HIGH);
        end
    end
endmodule

// File: rtl/gpic_pick.sv
module gpic_pick
    import gpic_pkg::*;
#(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]        cand,
    input  logic [N_SRC*RANK_W-1:0] rank,
    input  logic                    desig_hit,
    input  logic [IDX_W-1:0]        desig_idx,
    output logic                    valid,
    output logic [IDX_W-1:0]        win_idx
);
    logic [RANK_W-1:0] best;

    always_comb begin
        valid   = 1'b0;
        win_idx = '0;
        best    = '1;
        if (desig_hit) begin
            valid   = 1'b1;
            win_idx = desig_idx;
        end else begin
            // ascending scan: strict compare keeps lower group, then lower position
            for (int s = 0; s < N_SRC; s++)
                if (cand[s] && (!valid || rank[s*RANK_W +: RANK_W] < best)) begin
                    valid   = 1'b1;
                    best    = rank[s*RANK_W +: RANK_W];
                    win_idx = IDX_W'(s);
                end
        end
    end

    always_comb begin
        if (valid && !desig_hit)
            p_pick_is_candidate_r6: assert (cand[win_idx]);
    end
endmodule

// File: rtl/gpic.sv
module gpic
    import gpic_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    localparam int N_SRC = NUM_GROUPS * GRP_SIZE,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     irq_src,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_lo,
    output logic                 irq_hi
);
    localparam logic [SRC_W:0] N_SRC_V = (SRC_W + 1)'(N_SRC);

    logic [SRC_W-1:0]                   desig_src;
    logic [1:0]                         desig_line;
    logic [NUM_GROUPS*4-1:0]            route;
    logic [N_SRC-1:0]                   mask_bits;
    logic [NUM_GROUPS*SLOTS*CODE_W-1:0] slots;
    logic [N_SRC*RANK_W-1:0]            rank_all;
    logic [N_SRC-1:0]                   src_hi;
    logic [N_SRC-1:0]                   eligible, keep, cand_lo, cand_hi;
    logic                               desig_ok, desig_lo_hit, desig_hi_hit;
    logic [IDX_W-1:0]                   desig_idx, lo_idx, hi_idx;
    logic [DATA_W-1:0]                  vec_lo, vec_hi;

    gpic_regs #(.NUM_GROUPS(NUM_GROUPS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .vec_lo(vec_lo), .vec_hi(vec_hi), .rdata(bus_rdata),
        .desig_src(desig_src), .desig_line(desig_line), .route(route),
        .mask(mask_bits), .slots(slots)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        gpic_rank u_rank (
            .codes (slots[g*SLOTS*CODE_W +: SLOTS*CODE_W]),
            .route4(route[g*4 +: 4]),
            .rank  (rank_all[g*GRP_SIZE*RANK_W +: GRP_SIZE*RANK_W]),
            .to_hi (src_hi[g*GRP_SIZE +: GRP_SIZE])
        );
    end

    always_comb begin
        desig_ok     = (desig_src != '0) && ({1'b0, desig_src} < N_SRC_V);
        desig_idx    = desig_src[IDX_W-1:0];
        eligible     = irq_src & mask_bits & ~N_SRC'(1);
        keep         = desig_ok ? ~(N_SRC'(1) << desig_idx) : '1;
        cand_hi      = eligible & keep & src_hi;
        cand_lo      = eligible & keep & ~src_hi;
        desig_hi_hit = desig_ok && eligible[desig_idx] && (desig_line == LINE_HIGH);
        desig_lo_hit = desig_ok && eligible[desig_idx] && (desig_line != LINE_HIGH);
    end

    gpic_pick #(.N_SRC(N_SRC)) u_pick_lo (
        .cand(cand_lo), .rank(rank_all), .desig_hit(desig_lo_hit),
        .desig_idx(desig_idx), .valid(irq_lo), .win_idx(lo_idx)
    );

    gpic_pick #(.N_SRC(N_SRC)) u_pick_hi (
        .cand(cand_hi), .rank(rank_all), .desig_hit(desig_hi_hit),
        .desig_idx(desig_idx), .valid(irq_hi), .win_idx(hi_idx)
    );

    assign vec_lo = irq_lo ? {SRC_W'(lo_idx), {VEC_LSB{1'b0}}} : '0;
    assign vec_hi = irq_hi ? {SRC_W'(hi_idx), {VEC_LSB{1'b0}}} : '0;

    // R2: a winner is always a pending, enabled, real source
    p_lo_winner_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (irq_src[lo_idx] && mask_bits[lo_idx] && lo_idx != '0));
    p_hi_winner_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (irq_src[hi_idx] && mask_bits[hi_idx] && hi_idx != '0));
    // R9: the high line only carries routed slots or the designated source
    p_hi_needs_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && !desig_hi_hit) |-> src_hi[hi_idx]);
    // R10: designated source beats slot arbitration on its own line
    p_desig_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desig_lo_hit |-> (irq_lo && lo_idx == desig_idx));
    // R9/R10: no source wins both lines
    p_one_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_lo && irq_hi && lo_idx == hi_idx));
endmodule

// File: tb/gpic_test.sv
`timescale 1ns/1ps
module gpic_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpic uut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    localparam int NV = 16;
    // request pattern, expected low winner, expected high winner
    localparam logic [31:0] T_SRC [NV] = '{
        32'h0000_0000, // nothing                 R1-style idle
        32'h0000_0002, // src1 rank 3             R6
        32'h0000_0008, // src3 slot1 routed high  R9
        32'h0000_000A, // src3 + src1             R9
        32'h0000_0001, // src0 ignored            R2
        32'h4000_0000, // src30 disabled          R2
        32'h0100_0400, // src10 vs src24 slot1    R8
        32'h0180_0000, // src23 vs src24, Z field 10 stays low  R8 R9
        32'h0001_1000, // src16 routed slot2, src12 low         R9
        32'h0040_0002, // src22 vs src1 slot3     R8
        32'h0200_0084, // unlisted src2,src7,src25              R7
        32'h0000_0810, // unlisted src4 vs src11  R7
        32'h0080_0020, // src23 slot1 beats src5 slot2          R6
        32'h0001_0008, // two high sources        R6
        32'hFFFF_FFFF, // everything              R6 R8
        32'h0000_0020  // src5 slot2, route 00 -> low           R9
    };
    localparam logic [5:0] T_LO [NV] = '{
        6'd0, 6'd1, 6'd0, 6'd1, 6'd0, 6'd0, 6'd10, 6'd23,
        6'd12, 6'd1, 6'd2, 6'd4, 6'd23, 6'd0, 6'd10, 6'd5 };
    localparam logic [5:0] T_HI [NV] = '{
        6'd0, 6'd0, 6'd3, 6'd3, 6'd0, 6'd0, 6'd0, 6'd0,
        6'd16, 6'd0, 6'd0, 6'd0, 6'd0, 6'd3, 6'd3, 6'd0 };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        irq_src = v;
        #1;
    endtask

    task automatic chk_vec(input string tag, input logic [5:0] elo, input logic [5:0] ehi);
        logic [31:0] d;
        chk({tag, " R3 low line"}, {31'b0, irq_lo}, {31'b0, elo != 0});
        chk({tag, " R3 high line"}, {31'b0, irq_hi}, {31'b0, ehi != 0});
        rd(4'd2, d);
        chk({tag, " R4 low vector"}, d, {elo, 26'b0});
        rd(4'd3, d);
        chk({tag, " R4 high vector"}, d, {ehi, 26'b0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        irq_src = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset image
        rd(4'd0, d); chk("R1 ctrl after reset", d, 32'h0);
        rd(4'd1, d); chk("R1 route after reset", d, 32'h0);
        rd(4'd4, d); chk("R1 enable after reset", d, 32'h0);
        rd(4'd8, d); chk("R1 prio0 after reset", d, 32'h0);
        chk_vec("R1 all requests, nothing enabled", 6'd0, 6'd0);

        // configuration for the table (R11 readback)
        wr(4'd8,  32'h7480_0000);
        wr(4'd9,  32'h5100_2492);
        wr(4'd10, 32'hE300_7FFF);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, d); chk("R5 unused prio bits read zero", d, 32'hFF80_7FFF);
        wr(4'd11, 32'h0000_0000);
        wr(4'd1,  32'h0000_8104);
        rd(4'd1, d); chk("R11 route readback", d, 32'h0000_8104);
        wr(4'd4,  32'hBFFF_FFFF);
        rd(4'd4, d); chk("R11 enable readback", d, 32'hBFFF_FFFF);
        rd(4'd8, d); chk("R5 prio0 readback", d, 32'h7480_0000);

        for (int i = 0; i < NV; i++) begin
            drive(T_SRC[i]);
            chk_vec($sformatf("R6 table row %0d", i), T_LO[i], T_HI[i]);
        end

        // R4: writes to the vector words change nothing
        drive(32'h0000_000A);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd0, d); chk("R4 ctrl untouched by vector write", d, 32'h0);
        rd(4'd1, d); chk("R4 route untouched by vector write", d, 32'h0000_8104);
        chk_vec("R4 after vector write", 6'd1, 6'd3);

        // R10: designated source, line field 10 means low
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d); chk("R11 ctrl readback", d, 32'h0000_033F);
        wr(4'd0, 32'h0000_0218);
        drive(32'h0100_0400);
        chk_vec("R10 src24 designated low", 6'd24, 6'd0);
        // R10: designated high source leaves the low line
        wr(4'd0, 32'h0000_0105);
        drive(32'h0000_0028);
        chk_vec("R10 src5 designated high", 6'd0, 6'd5);
        // R10: disabled designated source has no effect
        wr(4'd0, 32'h0000_011E);
        drive(32'h4000_0008);
        chk_vec("R10 disabled designated src30", 6'd0, 6'd3);
        // R10: out-of-range number designates nothing
        wr(4'd0, 32'h0000_0128);
        drive(32'h0000_0028);
        chk_vec("R10 out of range designation", 6'd5, 6'd3);

        // R1: reset in mid-run clears everything
        drive(32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(4'd4, d); chk("R1 enable cleared by reset", d, 32'h0);
        rd(4'd9, d); chk("R1 prio1 cleared by reset", d, 32'h0);
        chk_vec("R1 after mid-run reset", 6'd0, 6'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule